// File: doc/BRIEF.md
# UART Character Buffers with Line Status

This block holds the byte queues and the line status word of a classic byte-oriented serial port. A host reaches it through a small register bus. Writing the data register queues a byte for the transmit shifter. Reading the data register takes the oldest received character. Writing the buffer control register selects the buffer depth and flushes either queue. Reading the status register returns the line status and then clears its sticky error bits. The shifters themselves sit outside the block. The receiver side delivers a one-cycle push strobe with a character and its error indications. The transmitter side takes bytes with a one-cycle pop strobe and reports when its shifter is idle.

Each receive slot is 16 bits wide. The low byte holds the character and the high byte holds the error flags that arrived with it. Those flags do not reach line status when they are pushed. They reach it only once their slot is the oldest one in the queue, and they are then wiped from the slot so that they are reported only once. Both queues have a capacity of 16 while the buffer-enable bit is set and 1 while it is clear. Any change of that bit empties both queues.

Top module: `uart_fifo_lsr`

## Requirements
- R1: After the synchronous active-low reset, both queues are empty, buffers are disabled (`fifo_mode`=0, capacity 1), `tx_avail` is 0, the idle counter is 0, and the status word reads 0x60.
- R2: Capacity is 16 while control bit 0 is 1 and 1 while it is 0. A control write that changes bit 0 empties both queues: status bit 0 clears, status bit 5 sets and `tx_avail` drops.
- R3: A control write with bit 1 set empties the receive queue and clears status bit 0 (data ready). A control write with bit 2 set empties the transmit queue and sets status bit 5 (holding empty).
- R4: Data-register writes queue bytes, and `tx_data` shows them in write order. A write to a full transmit queue replaces the byte in the slot at the write position and does not advance that position. Every data write clears status bits 5 and 6 one edge later.
- R5: Status bit 5 sets when a pop empties the transmit queue. Status bit 6 sets one edge after a cycle in which `tx_idle` is 1 and the transmit queue is empty, unless a data write happens in that cycle.
- R6: A push into a full receive queue that is not popped in the same cycle drops the character and sets status bits 1 (overrun) and 7 (receive error). Any push sets status bit 0.
- R7: A push stores the flags parity→bit 2, framing→bit 3, break→bit 4, with bit 7 set if any of them is set. These flags are ORed into status on the edge after their slot becomes the head. They are then cleared from the slot.
- R8: A status read returns the current word. On that edge, bits 1, 2, 3, 4 and 7 clear, except for flags merged or overruns recorded on the same edge. Bits 0, 5 and 6 are unaffected by the read.
- R9: A data read returns the head character, or 0 when the queue is empty, in the same cycle. It pops only a non-empty queue. Status bit 0 then shows whether entries remain.
- R10: `rx_idle_cnt` counts cycles with status bit 0 set and saturates at all ones. It clears on a push, on any data read and on a receive flush.
- R11: Received data bits above the word length (`word_len` 0..3 selects 5..8 bits) are zero when stored.
- R12: A push and a pop in the same cycle leave the receive count unchanged, so a full queue accepts the push without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 buffer control, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| word_len | input | 2 | Character length, 5 + value bits |
| rx_push | input | 1 | One-cycle strobe with a received character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error for the character |
| rx_ferr | input | 1 | Framing error for the character |
| rx_brk | input | 1 | Break condition for the character |
| tx_pop | input | 1 | Shifter takes the head byte |
| tx_idle | input | 1 | Transmit shifter idle |
| tx_data | output | 8 | Head byte of the transmit queue, 0 when empty |
| tx_avail | output | 1 | Transmit queue non-empty |
| fifo_mode | output | 1 | Current buffer-enable state |
| rx_idle_cnt | output | IDLE_W | Receive idle counter |

## Verification
Read data is combinational and is compared in the same cycle as the read strobe, before the edge that applies its side effects. Queue counts, data ready, overrun, holding-empty and the idle counter change on the first edge after their stimulus. Flags from a push into an empty queue need a second edge before they appear in status. Transmitter-empty follows one edge after the cycle in which the queue is seen empty. The bench drives each stimulus just after a falling edge and advances a reference model at the rising edge. It compares every output at the next falling edge and observes status only through bus reads, so each result is checked at the earliest cycle it is due.

// File: rtl/uart_fl_pkg.sv
// Shared constants and helpers for the UART buffer and status block.
// Assumes: 8-bit characters, status bit positions fixed by the host view.
package uart_fl_pkg;

    typedef enum logic [1:0] {
        REG_DATA  = 2'd0,
        REG_FCTL  = 2'd1,
        REG_LSTAT = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    localparam int LS_DR   = 0;
    localparam int LS_OVR  = 1;
    localparam int LS_PAR  = 2;
    localparam int LS_FRM  = 3;
    localparam int LS_BRK  = 4;
    localparam int LS_THRE = 5;
    localparam int LS_TEMT = 6;
    localparam int LS_RXE  = 7;

    // Bits cleared by a status read and fed by per-character flags
    localparam logic [7:0] LS_STICKY = 8'h9E;

    localparam int FC_EN    = 0;
    localparam int FC_RXRST = 1;
    localparam int FC_TXRST = 2;

    // Mask keeping only the configured number of data bits
    function automatic logic [7:0] word_mask(input logic [1:0] wl);
        logic [7:0] m;
        case (wl)
            2'd0:    m = 8'h1F;
            2'd1:    m = 8'h3F;
            2'd2:    m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

    // Per-character flags laid out in status-register positions
    function automatic logic [7:0] pack_flags(input logic pe, input logic fe, input logic bk);
        return {(pe | fe | bk), 2'b00, bk, fe, pe, 2'b00};
    endfunction

endpackage

// File: rtl/uart_fl_rxq.sv
// Receive queue: circular buffer of 16-bit slots {flags, data}.
// Capacity is DEPTH when fifo_en is set, 1 otherwise; the caller flushes
// whenever fifo_en changes. The head slot's flag byte is cleared on every
// edge it is the head, since the caller merges it into status that edge.
module uart_fl_rxq #(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          flush,
    input  logic          push,
    input  logic [15:0]   push_word,
    input  logic          pop_req,
    output logic [15:0]   head_word,
    output logic [CW-1:0] count,
    output logic          overflow,
    output logic          popped
);

    logic [15:0]   mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr, last_idx;
    logic [CW-1:0] cap;
    logic          full, accept;

    // Capacity and wrap index from the selected mode
    always_comb begin
        last_idx = fifo_en ? PW'(DEPTH - 1) : '0;
        cap      = fifo_en ? CW'(DEPTH) : CW'(1);
    end

    // Handshake decode for this cycle
    always_comb begin
        full     = (count == cap);
        popped   = pop_req && (count != '0) && !flush;
        accept   = push && !flush && (!full || popped);
        overflow = push && !flush && full && !popped;
    end

    assign head_word = mem[rd_ptr];

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p, input logic [PW-1:0] last);
        return (p == last) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (popped) rd_ptr <= step_ptr(rd_ptr, last_idx);
            if (accept) wr_ptr <= step_ptr(wr_ptr, last_idx);
            case ({accept, popped})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Slot storage: wipe head flags once merged, then store a new entry
    always_ff @(posedge clk) begin
        if (rst_n && !flush && (count != '0)) mem[rd_ptr][15:8] <= 8'h00;
        if (rst_n && accept) mem[wr_ptr] <= push_word;
    end

    // R2
    rx_count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);

    // R6
    rx_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (count == $past(count)));

endmodule

// File: rtl/uart_fl_txq.sv
// Transmit queue: circular byte buffer feeding the external shifter.
// Capacity DEPTH or 1 as selected by fifo_en. A write to a full queue
// replaces the byte at the write pointer without moving the pointer.
module uart_fl_txq #(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          flush,
    input  logic          wr,
    input  logic [7:0]    wr_data,
    input  logic          pop_req,
    output logic [7:0]    head_data,
    output logic [CW-1:0] count,
    output logic          popped
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr, last_idx;
    logic [CW-1:0] cap;
    logic          full, advance, overwrite;

    // Capacity and wrap index from the selected mode
    always_comb begin
        last_idx = fifo_en ? PW'(DEPTH - 1) : '0;
        cap      = fifo_en ? CW'(DEPTH) : CW'(1);
    end

    // Handshake decode for this cycle
    always_comb begin
        full      = (count == cap);
        popped    = pop_req && (count != '0) && !flush;
        advance   = wr && !flush && (!full || popped);
        overwrite = wr && !flush && full && !popped;
    end

    assign head_data = mem[rd_ptr];

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p, input logic [PW-1:0] last);
        return (p == last) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (popped)  rd_ptr <= step_ptr(rd_ptr, last_idx);
            if (advance) wr_ptr <= step_ptr(wr_ptr, last_idx);
            case ({advance, popped})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Byte storage: every accepted or overwriting write lands at wr_ptr
    always_ff @(posedge clk) begin
        if (rst_n && wr && !flush) mem[wr_ptr] <= wr_data;
    end

    // R4
    tx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !flush) |=> (count != '0));

    // R4
    tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overwrite |=> (count == $past(count)));

endmodule

// File: rtl/uart_fl_lsr.sv
// Line status register. Holds data-ready, sticky receive errors and the
// two transmit-empty indications. Sticky bits clear on a status read;
// merges and overruns recorded on the same edge survive that clear.
module uart_fl_lsr
    import uart_fl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_read,
    input  logic       rx_flush,
    input  logic       rx_push,
    input  logic       rx_popped,
    input  logic       rx_last,
    input  logic       rx_overflow,
    input  logic [7:0] head_flags,
    input  logic       tx_write,
    input  logic       tx_popped,
    input  logic       tx_last,
    input  logic       tx_empty,
    input  logic       tx_flush,
    input  logic       tx_idle,
    output logic [7:0] lsr
);

    logic       dr_q, thre_q, temt_q;
    logic [7:0] err_q, err_d;

    // Next sticky error set: clear on read, then merge new events
    always_comb begin
        err_d = stat_read ? 8'h00 : err_q;
        err_d = err_d | (head_flags & LS_STICKY);
        if (rx_overflow) begin
            err_d[LS_OVR] = 1'b1;
            err_d[LS_RXE] = 1'b1;
        end
    end

    // Sticky receive errors
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 8'h00;
        else        err_q <= err_d;
    end

    // Data-ready tracking
    always_ff @(posedge clk) begin
        if (!rst_n || rx_flush)       dr_q <= 1'b0;
        else if (rx_push)             dr_q <= 1'b1;
        else if (rx_popped && rx_last) dr_q <= 1'b0;
    end

    // Holding-empty tracking
    always_ff @(posedge clk) begin
        if (!rst_n || tx_flush)         thre_q <= 1'b1;
        else if (tx_write)              thre_q <= 1'b0;
        else if (tx_popped && tx_last)  thre_q <= 1'b1;
    end

    // Transmitter-empty tracking
    always_ff @(posedge clk) begin
        if (!rst_n)                    temt_q <= 1'b1;
        else if (tx_write)             temt_q <= 1'b0;
        else if (tx_idle && tx_empty)  temt_q <= 1'b1;
    end

    assign lsr = {err_q[LS_RXE], temt_q, thre_q, err_q[LS_BRK:LS_OVR], dr_q};

    // R3
    rx_flush_dr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> !lsr[LS_DR]);

    // R3
    tx_flush_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> lsr[LS_THRE]);

    // R6
    push_dr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_flush) |=> lsr[LS_DR]);

    // R4
    wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |=> (!lsr[LS_THRE] && !lsr[LS_TEMT]));

    // R8
    read_clears_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && (head_flags == 8'h00) && !rx_overflow) |=> ((lsr & LS_STICKY) == 8'h00));

endmodule

// File: rtl/uart_fifo_lsr.sv
// Top of the UART buffer and status block. Decodes the register bus,
// owns the buffer-enable bit, flush generation, the receive idle counter
// and the read multiplexer. Assumes bus_wr and bus_rd are single-cycle
// strobes; read data is combinational in the strobe cycle, side effects
// apply on the following edge.
module uart_fifo_lsr
    import uart_fl_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        word_len,
    input  logic              rx_push,
    input  logic [7:0]        rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              tx_pop,
    input  logic              tx_idle,
    output logic [7:0]        tx_data,
    output logic              tx_avail,
    output logic              fifo_mode,
    output logic [IDLE_W-1:0] rx_idle_cnt
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    reg_sel_e      sel;
    logic          wr_data, wr_fctl, rd_data, rd_stat, en_change;
    logic          rx_flush, tx_flush, fifo_en_q;
    logic [15:0]   push_word, rx_head;
    logic [CW-1:0] rx_count, tx_count;
    logic          rx_overflow, rx_popped, tx_popped;
    logic [7:0]    tx_head, head_flags, lsr;
    logic [IDLE_W-1:0] idle_q;

    // Register bus decode and flush requests
    always_comb begin
        sel       = reg_sel_e'(bus_addr);
        wr_data   = bus_wr && (sel == REG_DATA);
        wr_fctl   = bus_wr && (sel == REG_FCTL);
        rd_data   = bus_rd && (sel == REG_DATA);
        rd_stat   = bus_rd && (sel == REG_LSTAT);
        en_change = wr_fctl && (bus_wdata[FC_EN] != fifo_en_q);
        rx_flush  = wr_fctl && (bus_wdata[FC_RXRST] || en_change);
        tx_flush  = wr_fctl && (bus_wdata[FC_TXRST] || en_change);
    end

    // Buffer-enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)       fifo_en_q <= 1'b0;
        else if (wr_fctl) fifo_en_q <= bus_wdata[FC_EN];
    end

    assign push_word  = {pack_flags(rx_perr, rx_ferr, rx_brk), rx_data & word_mask(word_len)};
    assign head_flags = (rx_count != '0) ? rx_head[15:8] : 8'h00;

    uart_fl_rxq #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en_q),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_word (push_word),
        .pop_req   (rd_data),
        .head_word (rx_head),
        .count     (rx_count),
        .overflow  (rx_overflow),
        .popped    (rx_popped)
    );

    uart_fl_txq #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en_q),
        .flush     (tx_flush),
        .wr        (wr_data),
        .wr_data   (bus_wdata),
        .pop_req   (tx_pop),
        .head_data (tx_head),
        .count     (tx_count),
        .popped    (tx_popped)
    );

    uart_fl_lsr u_lsr (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_read   (rd_stat),
        .rx_flush    (rx_flush),
        .rx_push     (rx_push),
        .rx_popped   (rx_popped),
        .rx_last     (rx_count == CW'(1)),
        .rx_overflow (rx_overflow),
        .head_flags  (head_flags),
        .tx_write    (wr_data),
        .tx_popped   (tx_popped),
        .tx_last     (tx_count == CW'(1)),
        .tx_empty    (tx_count == '0),
        .tx_flush    (tx_flush),
        .tx_idle     (tx_idle),
        .lsr         (lsr)
    );

    // Receive idle counter, saturating, cleared by receive activity
    always_ff @(posedge clk) begin
        if (!rst_n)                              idle_q <= '0;
        else if (rx_push || rd_data || rx_flush) idle_q <= '0;
        else if (lsr[LS_DR] && (idle_q != '1))   idle_q <= idle_q + 1'b1;
    end

    // Read data multiplexer
    always_comb begin
        case (sel)
            REG_DATA:  bus_rdata = (rx_count != '0) ? rx_head[7:0] : 8'h00;
            REG_LSTAT: bus_rdata = lsr;
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign tx_avail    = (tx_count != '0);
    assign tx_data     = tx_avail ? tx_head : 8'h00;
    assign fifo_mode   = fifo_en_q;
    assign rx_idle_cnt = idle_q;

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rd_data || rx_flush) |=> (rx_idle_cnt == '0));

    // R2
    mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_change |=> (!tx_avail && (fifo_mode != $past(fifo_mode))));

endmodule

// File: tb/uart_fifo_lsr_test.sv
`timescale 1ns/100ps
module uart_fifo_lsr_test;

    localparam int D  = 16;
    localparam int IW = 8;

    logic          clk, rst_n;
    logic          bus_wr, bus_rd;
    logic [1:0]    bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic [1:0]    word_len;
    logic          rx_push, rx_perr, rx_ferr, rx_brk;
    logic [7:0]    rx_data;
    logic          tx_pop, tx_idle;
    logic [7:0]    tx_data;
    logic          tx_avail, fifo_mode;
    logic [IW-1:0] rx_idle_cnt;

    uart_fifo_lsr #(.DEPTH(D), .IDLE_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .word_len(word_len), .rx_push(rx_push), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .tx_pop(tx_pop), .tx_idle(tx_idle), .tx_data(tx_data),
        .tx_avail(tx_avail), .fifo_mode(fifo_mode), .rx_idle_cnt(rx_idle_cnt)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state
    logic       m_fen, m_dr, m_thre, m_temt;
    logic [7:0] m_err;
    logic [7:0] m_rxd [D];
    logic [7:0] m_rxf [D];
    logic [7:0] m_tx  [D];
    int m_rc, m_rh, m_rt, m_tc, m_tr, m_tw, m_idle;

    function automatic logic [7:0] f_mask(input logic [1:0] wl);
        return 8'((9'h1 << (5 + wl)) - 1);
    endfunction

    function automatic logic [7:0] f_flags(input logic pe, input logic fe, input logic bk);
        logic [7:0] f = 8'h00;
        f[2] = pe; f[3] = fe; f[4] = bk; f[7] = pe | fe | bk;
        return f;
    endfunction

    function automatic logic [7:0] f_lsr();
        return {m_err[7], m_temt, m_thre, m_err[4:1], m_dr};
    endfunction

    function automatic logic [7:0] f_rdata(input logic [1:0] a);
        if (a == 2'd0) return (m_rc > 0) ? m_rxd[m_rh] : 8'h00;
        if (a == 2'd2) return f_lsr();
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_fen = 0; m_dr = 0; m_thre = 1; m_temt = 1; m_err = 8'h00;
        m_rc = 0; m_rh = 0; m_rt = 0; m_tc = 0; m_tr = 0; m_tw = 0; m_idle = 0;
        for (int i = 0; i < D; i++) begin
            m_rxf[i] = 8'h00; m_rxd[i] = 8'h00; m_tx[i] = 8'h00;
        end
    endtask

    // One clock edge of the requirement-level behaviour
    task automatic model_step(input logic w, input logic r, input logic [1:0] a,
                              input logic [7:0] wd, input logic p, input logic [7:0] pd,
                              input logic pe, input logic fe, input logic bk,
                              input logic tp, input logic tid, input logic [1:0] wl);
        int cap = m_fen ? D : 1;
        bit wrd = w && a == 2'd0;
        bit wfc = w && a == 2'd1;
        bit rdd = r && a == 2'd0;
        bit rds = r && a == 2'd2;
        bit enc = wfc && (wd[0] != m_fen);
        bit frx = wfc && (wd[1] || enc);
        bit ftx = wfc && (wd[2] || enc);
        logic [7:0] nerr = rds ? 8'h00 : m_err;
        int nidle = m_idle;
        logic ntemt;
        int old_tc = m_tc;
        if (m_rc > 0) begin
            nerr = nerr | (m_rxf[m_rh] & 8'h9E);
            m_rxf[m_rh] = 8'h00;
        end
        if (p || rdd || frx) nidle = 0;
        else if (m_dr && m_idle < (1 << IW) - 1) nidle = m_idle + 1;
        if (frx) begin
            m_rc = 0; m_rh = 0; m_rt = 0; m_dr = 0;
        end else begin
            bit pp = rdd && m_rc > 0;
            bit full = (m_rc == cap);
            if (pp) begin m_rh = (m_rh + 1) % cap; m_rc--; end
            if (p) begin
                if (full && !pp) nerr = nerr | 8'h82;
                else begin
                    m_rxd[m_rt] = pd & f_mask(wl);
                    m_rxf[m_rt] = f_flags(pe, fe, bk);
                    m_rt = (m_rt + 1) % cap; m_rc++;
                end
                m_dr = 1;
            end else if (pp && m_rc == 0) m_dr = 0;
        end
        ntemt = wrd ? 1'b0 : (tid && old_tc == 0) ? 1'b1 : m_temt;
        if (ftx) begin
            m_tc = 0; m_tr = 0; m_tw = 0; m_thre = 1;
        end else begin
            bit tpp = tp && m_tc > 0;
            bit tfull = (m_tc == cap);
            if (tpp) begin m_tr = (m_tr + 1) % cap; m_tc--; end
            if (wrd) begin
                m_tx[m_tw] = wd;
                if (!tfull || tpp) begin m_tw = (m_tw + 1) % cap; m_tc++; end
            end
            if (wrd) m_thre = 0;
            else if (tpp && old_tc == 1) m_thre = 1;
        end
        if (wfc) m_fen = wd[0];
        m_err = nerr; m_temt = ntemt; m_idle = nidle;
    endtask

    // Drive one cycle, check reads before the edge and outputs after it
    task automatic cyc(input logic w, input logic r, input logic [1:0] a, input logic [7:0] wd,
                       input logic p, input logic [7:0] pd, input logic pe, input logic fe,
                       input logic bk, input logic tp, input string tag);
        logic [7:0] exp_rd;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = wd;
        rx_push = p; rx_data = pd; rx_perr = pe; rx_ferr = fe; rx_brk = bk; tx_pop = tp;
        exp_rd = f_rdata(a);
        #1;
        if (r) chk({tag, " read"}, bus_rdata, exp_rd);
        @(posedge clk);
        model_step(w, r, a, wd, p, pd, pe, fe, bk, tp, tx_idle, word_len);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; rx_push = 0; tx_pop = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
        chk({tag, " tx_avail"}, tx_avail, m_tc > 0);
        if (m_tc > 0) chk({tag, " tx_data"}, tx_data, m_tx[m_tr]);
        chk({tag, " fifo_mode"}, fifo_mode, m_fen);
        chk({tag, " idle_cnt"}, rx_idle_cnt, m_idle);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d, input string tag);
        cyc(1, 0, a, d, 0, 8'h00, 0, 0, 0, 0, tag);
    endtask
    task automatic rreg(input logic [1:0] a, input string tag);
        cyc(0, 1, a, 8'h00, 0, 8'h00, 0, 0, 0, 0, tag);
    endtask
    task automatic rpush(input logic [7:0] d, input logic pe, input logic fe, input logic bk, input string tag);
        cyc(0, 0, 2'd0, 8'h00, 1, d, pe, fe, bk, 0, tag);
    endtask
    task automatic idle_n(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 2'd3, 8'h00, 0, 8'h00, 0, 0, 0, 0, tag);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL all: watchdog act=running exp=finished");
        report();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; word_len = 2'd3;
        rx_push = 0; rx_data = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
        tx_pop = 0; tx_idle = 1; rst_n = 0;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        chk("R1 tx_avail", tx_avail, 1'b0);
        chk("R1 fifo_mode", fifo_mode, 1'b0);
        chk("R1 idle", rx_idle_cnt, 0);
        rreg(2'd2, "R1");
        chk("R1 lsr value", f_lsr(), 8'h60);

        // R11 word-length masking
        word_len = 2'd0; rpush(8'hFF, 0, 0, 0, "R11"); rreg(2'd0, "R11");
        word_len = 2'd1; rpush(8'hFF, 0, 0, 0, "R11"); rreg(2'd0, "R11");
        word_len = 2'd2; rpush(8'hA5, 0, 0, 0, "R11"); rreg(2'd0, "R11");
        word_len = 2'd3;

        // R6 overrun with single-entry capacity, R9 pop and empty read
        rpush(8'h41, 0, 0, 0, "R6");
        rpush(8'h42, 0, 0, 0, "R6");
        rreg(2'd2, "R6");
        rreg(2'd0, "R9");
        rreg(2'd0, "R9");
        rreg(2'd2, "R9");
        rreg(2'd2, "R8");

        // R2 enable 16 entries, fill, overrun, then toggle flushes
        wreg(2'd1, 8'h01, "R2");
        for (int i = 0; i < D; i++) rpush(8'(8'h10 + i), 0, 0, 0, "R2");
        rpush(8'hEE, 0, 0, 0, "R2");
        rreg(2'd2, "R2");
        for (int i = 0; i < 4; i++) rreg(2'd0, "R2");
        wreg(2'd0, 8'h33, "R2");
        wreg(2'd1, 8'h00, "R2");
        rreg(2'd2, "R2");
        rreg(2'd0, "R2");
        wreg(2'd1, 8'h01, "R2");

        // R7 per-entry flags merge at head; R8 read clears
        rpush(8'h01, 0, 0, 0, "R7");
        rpush(8'h02, 1, 0, 0, "R7");
        rpush(8'h03, 0, 1, 1, "R7");
        idle_n(2, "R7");
        rreg(2'd2, "R7");
        rreg(2'd0, "R7");
        idle_n(1, "R7");
        rreg(2'd2, "R7");
        rreg(2'd2, "R8");
        rreg(2'd0, "R7");
        idle_n(1, "R7");
        rreg(2'd2, "R7");
        rreg(2'd2, "R8");
        rreg(2'd0, "R9");
        rreg(2'd2, "R9");

        // R4 transmit ordering and full overwrite; R5 empty bits
        tx_idle = 0;
        for (int i = 0; i < D + 1; i++) wreg(2'd0, 8'(8'h80 + i), "R4");
        rreg(2'd2, "R4");
        for (int i = 0; i < D; i++) cyc(0, 0, 2'd3, 8'h00, 0, 8'h00, 0, 0, 0, 1, "R4");
        rreg(2'd2, "R5");
        tx_idle = 1; idle_n(1, "R5");
        rreg(2'd2, "R5");

        // R3 separate resets
        rpush(8'h55, 0, 0, 0, "R3");
        wreg(2'd0, 8'h66, "R3");
        wreg(2'd1, 8'h03, "R3");
        rreg(2'd2, "R3");
        wreg(2'd1, 8'h05, "R3");
        rreg(2'd2, "R3");

        // R12 simultaneous push and pop on a full queue
        for (int i = 0; i < D; i++) rpush(8'(i), 0, 0, 0, "R12");
        cyc(0, 1, 2'd0, 8'h00, 1, 8'h77, 0, 0, 0, 0, "R12");
        rreg(2'd2, "R12");
        for (int i = 0; i < D; i++) rreg(2'd0, "R12");

        // R10 idle counter saturates and clears
        rpush(8'h99, 0, 0, 0, "R10");
        idle_n(300, "R10");
        rreg(2'd0, "R10");
        idle_n(3, "R10");

        // Random mix against the model
        for (int n = 0; n < 5000; n++) begin
            int k = $urandom % 16;
            logic [7:0] d = 8'($urandom);
            logic pe = ($urandom % 6) == 0;
            logic fe = ($urandom % 8) == 0;
            logic bk = ($urandom % 12) == 0;
            if (($urandom % 40) == 0) word_len = 2'($urandom);
            tx_idle = ($urandom % 3) != 0;
            case (k)
                0, 1, 2:  rpush(d, pe, fe, bk, "R12 random push");
                3, 4:     rreg(2'd0, "R9 random data read");
                5:        rreg(2'd2, "R8 random status read");
                6, 7, 8:  wreg(2'd0, d, "R4 random write");
                9, 10:    cyc(0, 0, 2'd3, 8'h00, 0, 8'h00, 0, 0, 0, 1, "R5 random pop");
                11:       cyc(0, 1, 2'd0, 8'h00, 1, d, pe, fe, bk, 0, "R12 random push+pop");
                12:       cyc(1, 0, 2'd0, d, 0, 8'h00, 0, 0, 0, 1, "R4 random write+pop");
                13:       if (($urandom % 10) == 0) wreg(2'd1, 8'($urandom % 8), "R3 random control");
                          else idle_n(1, "R10 random idle");
                default:  idle_n(1, "R7 random idle");
            endcase
        end
        report();
    end

endmodule